// File: doc/BRIEF.md
# DMA Descriptor Configuration Checker

This block examines the settings of one DMA transfer descriptor and flags combinations that cannot be carried out. It looks at the source and destination addresses and their signed per-beat offsets, the transfer size code of each side, the minor-loop byte count, the scatter/gather target address and its enable, and the link-enable bits held in the current and starting iteration counters. The block does not move data or fetch descriptors. It only judges the settings it is given.

Each class of fault is tied to a specific moment in the channel's life, and three event strobes mark those moments. Alignment and byte-count faults are judged when the channel is activated. A misplaced scatter/gather address is judged only when the major loop completes. A link-bit disagreement is judged only when a minor loop completes. The verdict is a registered one-cycle pulse carrying a fault code. An interrupt request goes with it for activation-time faults when interrupts are enabled.

Top module: `dma_desc_checker`

## Requirements
- R1: The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 32 bytes. A source size code of 4 to 7 is reported at activation as code 1, and a destination size code of 4 to 7 as code 2.
- R2: At activation, a source address or source offset that is not a multiple of the source transfer size is reported as code 1.
- R3: At activation, a destination address or destination offset that is not a multiple of the destination transfer size is reported as code 2.
- R4: At activation, a minor-loop byte count that is not a multiple of both legal transfer sizes is reported as code 3.
- R5: The codes 1 to 3 are produced only by an `ev_activate` strobe. The result appears as a single-cycle `err_valid` pulse in the cycle after the strobe, and `err_valid` is low in the following cycle when no strobe is present.
- R6: On `ev_major_done` with `sga_en` high, a scatter/gather address whose low 5 bits are not all zero is reported as code 4. When `sga_en` is low, nothing is reported.
- R7: On `ev_minor_done` with `link_en` high, a difference between `cur_link` and `start_link` is reported as code 5. When the bits agree or `link_en` is low, nothing is reported.
- R8: When several faults are detected in the same cycle, only the lowest-numbered code is reported.
- R9: `err_irq` pulses together with `err_valid` only for codes 1 to 3, and only when `irq_en` was high in the strobe cycle.
- R10: After reset, and in every cycle without a reported fault, `err_valid`, `err_irq` and `err_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_addr | input | ADDR_W | Source start address |
| dst_addr | input | ADDR_W | Destination start address |
| src_ofs | input | OFS_W | Signed source offset per transfer |
| dst_ofs | input | OFS_W | Signed destination offset per transfer |
| src_size | input | 3 | Source transfer size code |
| dst_size | input | 3 | Destination transfer size code |
| nbytes | input | NB_W | Minor-loop byte count |
| sga_addr | input | ADDR_W | Scatter/gather descriptor address |
| sga_en | input | 1 | Scatter/gather enabled at completion |
| link_en | input | 1 | Minor-loop linking in use |
| cur_link | input | 1 | Link-enable bit of the current iteration count |
| start_link | input | 1 | Link-enable bit of the starting iteration count |
| irq_en | input | 1 | Error interrupt enable |
| ev_activate | input | 1 | Channel activation strobe |
| ev_minor_done | input | 1 | Minor-loop completion strobe |
| ev_major_done | input | 1 | Major-loop completion strobe |
| err_valid | output | 1 | Fault reported this cycle |
| err_code | output | 3 | Fault code (0 none, 1 source, 2 destination, 3 byte count, 4 scatter/gather, 5 link) |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench builds the checker with 8-bit addresses, 6-bit offsets and a 6-bit byte count. With these widths every residue that matters to the 32-byte alignment can be swept in full against all eight size codes on each side. The byte-count sweep covers every pair of legal sizes against all 64 counts. The scatter/gather sweep walks all 256 addresses with the enable both on and off. All eight link-bit combinations are tried, along with strobes issued together, so that priority and event gating are checked while faults of other classes are deliberately present.

// File: rtl/dmachk_pkg.sv
package dmachk_pkg;
  localparam int MASK_W = 5;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_SRC  = 3'd1,
    ERR_DST  = 3'd2,
    ERR_CNT  = 3'd3,
    ERR_SG   = 3'd4,
    ERR_LINK = 3'd5
  } err_code_e;
endpackage

// File: rtl/dmachk_size_decode.sv
module dmachk_size_decode #(
  parameter int MASK_W = 5
) (
  input  logic [2:0]        size_code,
  output logic              legal,
  output logic [MASK_W-1:0] low_mask
);
  always_comb begin
    legal    = 1'b1;
    low_mask = '0;
    case (size_code)
      3'd0: low_mask = MASK_W'(0);
      3'd1: low_mask = MASK_W'(1);
      3'd2: low_mask = MASK_W'(3);
      3'd3: low_mask = MASK_W'(31);
      default: begin
        legal    = 1'b0;
        low_mask = '0;
      end
    endcase
  end
endmodule

// File: rtl/dmachk_align_check.sv
module dmachk_align_check #(
  parameter int VAL_W  = 32,
  parameter int MASK_W = 5
) (
  input  logic [VAL_W-1:0]  value,
  input  logic [MASK_W-1:0] low_mask,
  output logic              misaligned
);
  logic [VAL_W-1:0] wide_mask;

  generate
    if (VAL_W > MASK_W) begin : g_ext
      assign wide_mask = {{(VAL_W-MASK_W){1'b0}}, low_mask};
    end else begin : g_same
      assign wide_mask = low_mask;
    end
  endgenerate

  assign misaligned = |(value & wide_mask);
endmodule

// File: rtl/dmachk_side_check.sv
module dmachk_side_check #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int MASK_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [2:0]        size_code,
  output logic              bad,
  output logic              legal,
  output logic [MASK_W-1:0] low_mask
);
  logic addr_mis;
  logic ofs_mis;

  dmachk_size_decode #(.MASK_W(MASK_W)) u_dec (
    .size_code (size_code),
    .legal     (legal),
    .low_mask  (low_mask)
  );

  dmachk_align_check #(.VAL_W(ADDR_W), .MASK_W(MASK_W)) u_addr (
    .value      (addr),
    .low_mask   (low_mask),
    .misaligned (addr_mis)
  );

  dmachk_align_check #(.VAL_W(OFS_W), .MASK_W(MASK_W)) u_ofs (
    .value      (ofs),
    .low_mask   (low_mask),
    .misaligned (ofs_mis)
  );

  assign bad = !legal || addr_mis || ofs_mis;
endmodule

// File: rtl/dmachk_err_select.sv
module dmachk_err_select
  import dmachk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       act,
  input  logic       src_bad,
  input  logic       dst_bad,
  input  logic       cnt_bad,
  input  logic       sg_bad,
  input  logic       link_bad,
  input  logic       irq_en,
  output logic       err_valid,
  output logic [2:0] err_code,
  output logic       err_irq
);
  err_code_e code_d, code_q;
  logic      irq_d, irq_q, valid_q;

  always_comb begin
    code_d = ERR_NONE;
    if (act && src_bad)      code_d = ERR_SRC;
    else if (act && dst_bad) code_d = ERR_DST;
    else if (act && cnt_bad) code_d = ERR_CNT;
    else if (sg_bad)         code_d = ERR_SG;
    else if (link_bad)       code_d = ERR_LINK;
    irq_d = irq_en && (code_d == ERR_SRC || code_d == ERR_DST || code_d == ERR_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= ERR_NONE;
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      code_q  <= code_d;
      valid_q <= (code_d != ERR_NONE);
      irq_q   <= irq_d;
    end
  end

  assign err_valid = valid_q;
  assign err_code  = code_q;
  assign err_irq   = irq_q;
endmodule

// File: rtl/dma_desc_checker.sv
module dma_desc_checker
  import dmachk_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int OFS_W        = 16,
  parameter int NB_W         = 16,
  parameter int SG_ALIGN_LG2 = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [OFS_W-1:0]  src_ofs,
  input  logic [OFS_W-1:0]  dst_ofs,
  input  logic [2:0]        src_size,
  input  logic [2:0]        dst_size,
  input  logic [NB_W-1:0]   nbytes,
  input  logic [ADDR_W-1:0] sga_addr,
  input  logic              sga_en,
  input  logic              link_en,
  input  logic              cur_link,
  input  logic              start_link,
  input  logic              irq_en,
  input  logic              ev_activate,
  input  logic              ev_minor_done,
  input  logic              ev_major_done,
  output logic              err_valid,
  output logic [2:0]        err_code,
  output logic              err_irq
);
  localparam int NSIDE = 2;
  localparam logic [ADDR_W-1:0] SG_MASK = ADDR_W'((64'd1 << SG_ALIGN_LG2) - 64'd1);

  logic [NSIDE-1:0][ADDR_W-1:0] side_addr;
  logic [NSIDE-1:0][OFS_W-1:0]  side_ofs;
  logic [NSIDE-1:0][2:0]        side_size;
  logic [NSIDE-1:0]             side_bad;
  logic [NSIDE-1:0]             side_legal;
  logic [NSIDE-1:0][MASK_W-1:0] side_mask;

  assign side_addr = {dst_addr, src_addr};
  assign side_ofs  = {dst_ofs, src_ofs};
  assign side_size = {dst_size, src_size};

  generate
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
      dmachk_side_check #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .MASK_W(MASK_W)) u_side (
        .addr      (side_addr[s]),
        .ofs       (side_ofs[s]),
        .size_code (side_size[s]),
        .bad       (side_bad[s]),
        .legal     (side_legal[s]),
        .low_mask  (side_mask[s])
      );
    end
  endgenerate

  logic cnt_mis;
  logic cnt_bad;
  logic sg_bad;
  logic link_bad;

  dmachk_align_check #(.VAL_W(NB_W), .MASK_W(MASK_W)) u_cnt (
    .value      (nbytes),
    .low_mask   (side_mask[0] | side_mask[1]),
    .misaligned (cnt_mis)
  );

  assign cnt_bad  = &side_legal && cnt_mis;
  assign sg_bad   = ev_major_done && sga_en && |(sga_addr & SG_MASK);
  assign link_bad = ev_minor_done && link_en && (cur_link != start_link);

  dmachk_err_select u_sel (
    .clk       (clk),
    .rst       (rst),
    .act       (ev_activate),
    .src_bad   (side_bad[0]),
    .dst_bad   (side_bad[1]),
    .cnt_bad   (cnt_bad),
    .sg_bad    (sg_bad),
    .link_bad  (link_bad),
    .irq_en    (irq_en),
    .err_valid (err_valid),
    .err_code  (err_code),
    .err_irq   (err_irq)
  );
endmodule

// File: rtl/dma_desc_checker_sva.sv
module dma_desc_checker_sva #(
  parameter int ADDR_W       = 32,
  parameter int SG_ALIGN_LG2 = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sga_addr,
  input logic              sga_en,
  input logic              link_en,
  input logic              cur_link,
  input logic              start_link,
  input logic              ev_activate,
  input logic              ev_minor_done,
  input logic              ev_major_done,
  input logic              err_valid,
  input logic [2:0]        err_code,
  input logic              err_irq
);
  // R5 / R10: no strobe, no report next cycle
  a_r5_quiet_after_idle: assert property (@(posedge clk) disable iff (rst)
    !(ev_activate || ev_minor_done || ev_major_done) |=> !err_valid);

  // R5: activation-class codes come only from an activation strobe
  a_r5_act_codes: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code >= 3'd1 && err_code <= 3'd3) |-> $past(ev_activate));

  // R6: scatter/gather code only from an enabled major completion
  a_r6_sg_origin: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code == 3'd4) |-> $past(ev_major_done && sga_en));

  // R6: a misplaced scatter/gather address is reported when nothing outranks it
  a_r6_sg_reported: assert property (@(posedge clk) disable iff (rst)
    (ev_major_done && sga_en && !ev_activate && (sga_addr[SG_ALIGN_LG2-1:0] != '0))
      |=> (err_valid && err_code == 3'd4));

  // R7: link code only from a disagreeing link service
  a_r7_link_origin: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code == 3'd5) |-> $past(ev_minor_done && link_en && (cur_link != start_link)));

  // R8: reported code is a defined fault
  a_r8_code_range: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code != 3'd0 && err_code <= 3'd5));

  // R9: interrupt only with an activation-class report
  a_r9_irq_class: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> (err_valid && err_code <= 3'd3));

  // R10: idle code is zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> (err_code == 3'd0 && !err_irq));
endmodule

bind dma_desc_checker dma_desc_checker_sva #(.ADDR_W(ADDR_W), .SG_ALIGN_LG2(SG_ALIGN_LG2)) u_sva (
  .clk           (clk),
  .rst           (rst),
  .sga_addr      (sga_addr),
  .sga_en        (sga_en),
  .link_en       (link_en),
  .cur_link      (cur_link),
  .start_link    (start_link),
  .ev_activate   (ev_activate),
  .ev_minor_done (ev_minor_done),
  .ev_major_done (ev_major_done),
  .err_valid     (err_valid),
  .err_code      (err_code),
  .err_irq       (err_irq)
);

// File: tb/tb_dma_desc_checker.sv
`timescale 1ns/1ps
module tb_dma_desc_checker;
  localparam int ADDR_W = 8;
  localparam int OFS_W  = 6;
  localparam int NB_W   = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] src_addr = '0, dst_addr = '0, sga_addr = '0;
  logic [OFS_W-1:0]  src_ofs = '0, dst_ofs = '0;
  logic [2:0]        src_size = '0, dst_size = '0;
  logic [NB_W-1:0]   nbytes = '0;
  logic sga_en = 0, link_en = 0, cur_link = 0, start_link = 0, irq_en = 0;
  logic ev_activate = 0, ev_minor_done = 0, ev_major_done = 0;
  logic err_valid, err_irq;
  logic [2:0] err_code;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  dma_desc_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .NB_W(NB_W), .SG_ALIGN_LG2(5)) dut (
    .clk(clk), .rst(rst), .src_addr(src_addr), .dst_addr(dst_addr),
    .src_ofs(src_ofs), .dst_ofs(dst_ofs), .src_size(src_size), .dst_size(dst_size),
    .nbytes(nbytes), .sga_addr(sga_addr), .sga_en(sga_en), .link_en(link_en),
    .cur_link(cur_link), .start_link(start_link), .irq_en(irq_en),
    .ev_activate(ev_activate), .ev_minor_done(ev_minor_done), .ev_major_done(ev_major_done),
    .err_valid(err_valid), .err_code(err_code), .err_irq(err_irq)
  );

  // byte size minus one per size code; illegal codes give -1
  function automatic int size_low(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 3;
      3'd3: return 31;
      default: return -1;
    endcase
  endfunction

  function automatic bit side_bad(input logic [2:0] c, input int a, input int o);
    int m = size_low(c);
    if (m < 0) return 1;
    return ((a % (m + 1)) != 0) || ((o % (m + 1)) != 0);
  endfunction

  function automatic logic [2:0] expect_code(input bit a, input bit mj, input bit mn);
    int ms = size_low(src_size);
    int md = size_low(dst_size);
    if (a && side_bad(src_size, int'(src_addr), int'(src_ofs))) return 3'd1;
    if (a && side_bad(dst_size, int'(dst_addr), int'(dst_ofs))) return 3'd2;
    if (a && ((int'(nbytes) % (ms + 1)) != 0 || (int'(nbytes) % (md + 1)) != 0)) return 3'd3;
    if (mj && sga_en && (int'(sga_addr) % 32) != 0) return 3'd4;
    if (mn && link_en && (cur_link != start_link)) return 3'd5;
    return 3'd0;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fire(input bit a, input bit mj, input bit mn, input string tag);
    logic [2:0] ec;
    logic       ei;
    ec = expect_code(a, mj, mn);
    ei = irq_en && (ec >= 3'd1) && (ec <= 3'd3);
    @(negedge clk);
    ev_activate = a; ev_major_done = mj; ev_minor_done = mn;
    @(negedge clk);
    ev_activate = 0; ev_major_done = 0; ev_minor_done = 0;
    check(tag, {err_valid, err_code, err_irq} == {(ec != 3'd0), ec, ei},
          int'({err_valid, err_code, err_irq}), int'({(ec != 3'd0), ec, ei}));
    @(negedge clk);
    check("R5 single pulse", !err_valid && err_code == 3'd0 && !err_irq,
          int'({err_valid, err_code, err_irq}), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", !err_valid && err_code == 3'd0 && !err_irq,
          int'({err_valid, err_code, err_irq}), 0);
    rst = 0;
    @(negedge clk);
    check("R10 idle after reset", !err_valid && err_code == 3'd0,
          int'({err_valid, err_code}), 0);

    // R1 R2: source size codes against address and offset residues
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 64; v++) begin
        src_size = 3'(s); src_addr = ADDR_W'(v); src_ofs = '0; irq_en = v[0];
        fire(1, 0, 0, "R2 src addr");
        src_addr = '0; src_ofs = OFS_W'(v);
        fire(1, 0, 0, "R2 src ofs");
      end
    end
    src_size = '0; src_addr = '0; src_ofs = '0;

    // R1 R3: destination side
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 64; v++) begin
        dst_size = 3'(s); dst_addr = ADDR_W'(v + 64); dst_ofs = '0; irq_en = v[1];
        fire(1, 0, 0, "R3 dst addr");
        dst_addr = '0; dst_ofs = OFS_W'(v);
        fire(1, 0, 0, "R3 dst ofs");
      end
    end
    dst_size = '0; dst_addr = '0; dst_ofs = '0;

    // R4 R9: byte count against every legal size pair
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        for (int n = 0; n < 64; n++) begin
          src_size = 3'(s); dst_size = 3'(d); nbytes = NB_W'(n); irq_en = n[2];
          fire(1, 0, 0, "R4 byte count");
        end
      end
    end
    src_size = '0; dst_size = '0; nbytes = '0;

    // R6 R5: scatter/gather sweep with an activation-class fault present
    src_size = 3'd1; src_addr = 8'h01; irq_en = 1;
    for (int e = 0; e < 2; e++) begin
      for (int v = 0; v < 256; v++) begin
        sga_en = e[0]; sga_addr = ADDR_W'(v);
        fire(0, 1, 0, "R6 sg address");
      end
    end
    sga_en = 0; sga_addr = '0;

    // R7: link bit combinations
    for (int k = 0; k < 8; k++) begin
      link_en = k[0]; cur_link = k[1]; start_link = k[2];
      fire(0, 0, 1, "R7 link bits");
    end

    // R8: simultaneous strobes
    sga_en = 1; sga_addr = 8'h10; link_en = 1; cur_link = 1; start_link = 0;
    dst_size = 3'd7;
    fire(1, 1, 1, "R8 src outranks all");
    src_size = 3'd0; src_addr = '0;
    fire(1, 1, 1, "R8 dst outranks sg");
    dst_size = 3'd0;
    fire(1, 1, 1, "R8 sg outranks link");
    fire(0, 1, 1, "R8 sg over link");
    irq_en = 0; nbytes = 6'd1; src_size = 3'd1;
    fire(1, 1, 1, "R9 count no irq");
    fire(0, 0, 1, "R9 link no irq");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule